// File: doc/BRIEF.md
# Outstanding Read Request Engine

This block fetches a run of N consecutive words from a memory that answers in order but with a variable delay. A command carries a start strobe and a length. The engine then sends element indices 0 to N-1 on a ready/valid address stream. It collects the returned words on a ready/valid data stream and forwards each word, tagged with its position, on a ready/valid result stream.

Two counters are kept. One counts the addresses the memory has taken and the other counts the responses accepted. Because the two counters are separate, a new address can go out in the same cycle as a word comes back. Many requests can wait in the memory at once, up to a depth set by a parameter. This hides the memory latency behind a steady flow of one word per cycle. The command is complete only when the last response has been accepted. At that point a single-cycle done pulse is raised.

Top module: `rd_engine`

## Requirements
- R1: After reset, and for each accepted command, both counters start from zero. The first address offered carries index 0 and appears in the cycle after the start strobe is sampled. After reset, address valid, data ready and done are all low.
- R2: Done rises for exactly one cycle. It is high in the cycle after the clock edge where the N-th response is accepted, and never when only the last address has been sent.
- R3: An address is offered only while fewer than N addresses have been taken. While the address is offered and not taken, the same index stays valid. The index advances by one only on a completed handshake.
- R4: Returned data is accepted independently of address issue, so one address handshake and one data handshake can complete on the same edge.
- R5: The count of addresses taken minus responses accepted never exceeds MAX_OUT. When a run is limited only by latency, this count reaches MAX_OUT.
- R6: When no stream is stalled and the latency is below MAX_OUT, addresses are taken on N consecutive edges and responses are accepted on N consecutive edges.
- R7: The result stream is a same-cycle copy of the accepted data. Results come in arrival order, and the index field equals the number of responses accepted earlier in the command. Data ready is never high while result ready is low.
- R8: A start strobe seen while a command is running is ignored. The running command completes with its original length, and only one done pulse is raised.
- R9: A command of length zero takes no address and raises done in the cycle after its start strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| len_i | input | IDX_W | Number of words to fetch |
| addr_valid_o | output | 1 | Address offered |
| addr_ready_i | input | 1 | Memory takes the address |
| addr_idx_o | output | IDX_W | Element index being requested |
| rdat_valid_i | input | 1 | Returned word present |
| rdat_ready_o | output | 1 | Engine accepts returned word |
| rdat_i | input | DATA_W | Returned word |
| res_valid_o | output | 1 | Result word present |
| res_ready_i | input | 1 | Consumer takes the result |
| res_data_o | output | DATA_W | Result word |
| res_idx_o | output | IDX_W | Position of the result word in the run |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first address is due on the first rising edge after the edge that samples the start strobe. Each result is due combinationally in the same cycle as the data handshake. Done is due one edge after the last data handshake, and for a zero-length command one edge after the start is sampled. The bench drives every input on the falling edge. It records all handshakes, edge numbers and in-flight counts on the rising edge. Each scenario task then compares the recorded edge numbers against these offsets. The memory model is an in-order queue that delays each response by a set or pseudo-random number of cycles.

// File: rtl/rd_engine.sv
module rd_engine #(
  parameter int IDX_W   = 16,
  parameter int DATA_W  = 32,
  parameter int MAX_OUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  len_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [IDX_W-1:0]  addr_idx_o,
  input  logic              rdat_valid_i,
  output logic              rdat_ready_o,
  input  logic [DATA_W-1:0] rdat_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] CAP = IDX_W'(MAX_OUT);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] len_q, sent_q, got_q;
  logic [IDX_W-1:0] pending;
  logic             addr_fire, data_fire, last_resp;

  assign pending   = sent_q - got_q;
  assign addr_fire = addr_valid_o && addr_ready_i;
  assign data_fire = rdat_valid_i && rdat_ready_o;
  assign last_resp = data_fire && (got_q == len_q - 1'b1);

  assign addr_valid_o = busy_q && (sent_q != len_q) && (pending < CAP);
  assign addr_idx_o   = sent_q;

  assign rdat_ready_o = busy_q && res_ready_i && (pending != '0);
  assign res_valid_o  = busy_q && rdat_valid_i && (pending != '0);
  assign res_data_o   = rdat_i;
  assign res_idx_o    = got_q;
  assign done_o       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      len_q  <= '0;
      sent_q <= '0;
      got_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          len_q  <= len_i;
          sent_q <= '0;
          got_q  <= '0;
          busy_q <= (len_i != '0);
          done_q <= (len_i == '0);
        end
      end else begin
        if (addr_fire) sent_q <= sent_q + 1'b1;
        if (data_fire) got_q  <= got_q + 1'b1;
        if (last_resp) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assert_inflight_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pending <= CAP));

  assert_issue_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (sent_q <= len_q));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && addr_idx_o == $past(addr_idx_o)));

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_q);

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_ready_o |-> res_ready_i);
endmodule

// File: tb/sim_rd_engine.sv
module sim_rd_engine;
  localparam int PERIOD = 10;
  localparam int IDX_W = 16;
  localparam int DATA_W = 32;
  localparam int MAX_OUT = 8;

  logic clk = 0, rst_n = 0;
  logic start_i = 0;
  logic [IDX_W-1:0] len_i = '0;
  logic addr_ready_i = 0, rdat_valid_i = 0, res_ready_i = 0;
  logic [DATA_W-1:0] rdat_i = '0;
  logic addr_valid_o, rdat_ready_o, res_valid_o, done_o;
  logic [IDX_W-1:0] addr_idx_o, res_idx_o;
  logic [DATA_W-1:0] res_data_o;

  rd_engine #(.IDX_W(IDX_W), .DATA_W(DATA_W), .MAX_OUT(MAX_OUT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i), .addr_idx_o(addr_idx_o),
    .rdat_valid_i(rdat_valid_i), .rdat_ready_o(rdat_ready_o), .rdat_i(rdat_i),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_data_o(res_data_o),
    .res_idx_o(res_idx_o), .done_o(done_o));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  int lat_base = 1, lat_spread = 0, ar_mode = 0, rr_mode = 0, salt = 0;
  logic [31:0] lfsr = 32'h1234_5678;
  int qidx[$], qdue[$];
  int last_due = 0;
  int n_addr, n_res, n_done, max_infl, both_cnt;
  int first_addr, last_addr, first_acc, last_acc, done_cyc;
  int bad_order, bad_hold, bad_bp, start_cyc;
  bit prev_stall = 0;
  logic [IDX_W-1:0] prev_idx = '0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(addr_valid_o && addr_idx_o == prev_idx)) bad_hold++;
      prev_stall = addr_valid_o && !addr_ready_i;
      prev_idx = addr_idx_o;
      if (addr_valid_o && addr_ready_i) begin
        int d;
        if (int'(addr_idx_o) != n_addr) bad_order++;
        d = cyc + lat_base + (lat_spread > 0 ? int'(lfsr[7:0]) % (lat_spread + 1) : 0);
        if (d < last_due) d = last_due;
        last_due = d;
        qidx.push_back(int'(addr_idx_o));
        qdue.push_back(d);
        if (n_addr == 0) first_addr = cyc;
        last_addr = cyc;
        n_addr++;
        if (rdat_valid_i && rdat_ready_o) both_cnt++;
      end
      if (rdat_valid_i && rdat_ready_o) begin
        void'(qidx.pop_front());
        void'(qdue.pop_front());
      end
      if (res_valid_o && res_ready_i) begin
        if (int'(res_idx_o) != n_res || res_data_o != DATA_W'(n_res * 7 + salt)) bad_order++;
        if (n_res == 0) first_acc = cyc;
        last_acc = cyc;
        n_res++;
      end
      if (rdat_ready_o && !res_ready_i) bad_bp++;
      if (n_addr - n_res > max_infl) max_infl = n_addr - n_res;
      if (done_o) begin
        n_done++;
        done_cyc = cyc;
      end
    end
    cyc++;
  end

  always @(negedge clk) begin
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    addr_ready_i = (ar_mode == 0) ? 1'b1 : lfsr[3];
    res_ready_i  = (rr_mode == 0) ? 1'b1 : lfsr[9];
    rdat_valid_i = (qidx.size() > 0) && (qdue[0] <= cyc);
    rdat_i       = (qidx.size() > 0) ? DATA_W'(qidx[0] * 7 + salt) : '0;
  end

  task automatic clear_stats(int s);
    salt = s; n_addr = 0; n_res = 0; n_done = 0; max_infl = 0; both_cnt = 0;
    first_addr = -1; last_addr = -1; first_acc = -1; last_acc = -1; done_cyc = -1;
    bad_order = 0; bad_hold = 0; bad_bp = 0; last_due = 0;
  endtask

  task automatic pulse_start(int len);
    @(negedge clk);
    start_i = 1; len_i = IDX_W'(len); start_cyc = cyc;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (n_done == 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk({req, " timeout"}, int'(n_done > 0), 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset addr_valid", int'(addr_valid_o), 0);
    chk("R1 reset rdat_ready", int'(rdat_ready_o), 0);
    chk("R1 reset done", int'(done_o), 0);
  endtask

  task automatic t_basic();
    lat_base = 3; lat_spread = 4; ar_mode = 1; rr_mode = 0;
    clear_stats(100);
    pulse_start(12);
    wait_done("R2 basic");
    chk("R2 results", n_res, 12);
    chk("R3 addresses", n_addr, 12);
    chk("R3 hold on stall", bad_hold, 0);
    chk("R7 order and tag", bad_order, 0);
    chk("R2 done after last accept", done_cyc, last_acc + 1);
    chk("R2 single pulse", n_done, 1);
  endtask

  task automatic t_full();
    lat_base = 4; lat_spread = 0; ar_mode = 0; rr_mode = 0;
    clear_stats(200);
    pulse_start(32);
    wait_done("R6 full");
    chk("R1 first address edge", first_addr, start_cyc + 1);
    chk("R6 address span", last_addr - first_addr, 31);
    chk("R6 response span", last_acc - first_acc, 31);
    chk("R4 same edge issue and accept", int'(both_cnt > 0), 1);
    chk("R7 order full", bad_order, 0);
  endtask

  task automatic t_cap();
    lat_base = 20; lat_spread = 0; ar_mode = 0; rr_mode = 0;
    clear_stats(300);
    pulse_start(30);
    wait_done("R5 cap");
    chk("R5 max in flight", max_infl, MAX_OUT);
    chk("R5 results", n_res, 30);
  endtask

  task automatic t_backpressure();
    lat_base = 2; lat_spread = 3; ar_mode = 1; rr_mode = 1;
    clear_stats(400);
    pulse_start(20);
    wait_done("R7 bp");
    chk("R7 no accept while result stalled", bad_bp, 0);
    chk("R7 order bp", bad_order, 0);
    chk("R3 hold bp", bad_hold, 0);
    chk("R7 results bp", n_res, 20);
  endtask

  task automatic t_ignore();
    lat_base = 5; lat_spread = 0; ar_mode = 1; rr_mode = 0;
    clear_stats(500);
    pulse_start(10);
    repeat (3) @(negedge clk);
    start_i = 1; len_i = 3;
    @(negedge clk);
    start_i = 0;
    wait_done("R8 ignore");
    chk("R8 results keep length", n_res, 10);
    chk("R8 addresses keep length", n_addr, 10);
    chk("R8 order", bad_order, 0);
    chk("R8 one done", n_done, 1);
  endtask

  task automatic t_zero();
    lat_base = 1; lat_spread = 0; ar_mode = 0; rr_mode = 0;
    clear_stats(600);
    pulse_start(0);
    wait_done("R9 zero");
    chk("R9 done edge", done_cyc, start_cyc + 1);
    chk("R9 no address", n_addr, 0);
    chk("R9 one done", n_done, 1);
  endtask

  task automatic t_restart();
    lat_base = 2; lat_spread = 2; ar_mode = 0; rr_mode = 1;
    clear_stats(700);
    pulse_start(5);
    wait_done("R1 restart");
    chk("R1 counters restart", bad_order, 0);
    chk("R1 results restart", n_res, 5);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_stats(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_full();
    t_cap();
    t_backpressure();
    t_ignore();
    t_zero();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule